// File: doc/BRIEF.md
# BCD Clock Calendar with Alarm

This block keeps the time of day and the calendar date as packed BCD fields: seconds, minutes, hours in 24-hour form, day of week, date, month, year and century. A one-cycle enable pulse, one per second, advances the count. Month lengths come from the month and year, and the leap-year rule uses the century field.

The state is held twice. An internal copy advances on every tick. A host-visible copy normally follows it. The host can freeze the visible copy to read a consistent snapshot while the internal copy keeps counting. Writes made during a freeze are held in the visible copy and are loaded into the internal count when the freeze is released.

A byte-wide register port gives access to the visible time fields, an alarm compare set, a control byte and a flags byte. When the internal time reaches the alarm values, a flag is latched and drives the interrupt output. The flag stays set until the host reads the flags byte.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 01, date 01, month 01, year 00 and century 20. The control byte, the flags byte and irq are all 0.
- R2: Register selects 0 to 7 hold seconds, minutes, hours, day of week, date, month, year and century, in that order. Each tick advances seconds in BCD. Seconds carry from 59 into minutes, minutes carry from 59 into hours, and 23:59:59 wraps to 00:00:00 and advances the day.
- R3: The date rolls to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. After month 12 comes month 01 with the year advanced. After year 99 comes year 00 with the century advanced.
- R4: February ends on 29 when century*100+year is divisible by 4, except when it is divisible by 100 and not by 400. Otherwise February ends on 28.
- R5: On each day change, the day of week steps from 1 up to 7 and then wraps back to 1.
- R6: Bit 0 of the control byte (select 12) freezes the visible copy. While it is 1, reads of selects 0 to 7 hold their values and the internal count keeps advancing. Clearing the bit makes the reads show the current internal time.
- R7: When the copy is not frozen, a write to a time field loads the internal count directly. Later ticks advance from the written value.
- R8: A write to a time field during a freeze reads back at once. At release it replaces that field of the internal count, and other fields keep their advanced values.
- R9: Selects 8 to 11 hold the alarm seconds, minutes, hours and date. When a tick brings the internal time to values equal to all four, irq rises two clock cycles after the cycle in which that tick was sampled. This also happens while the copy is frozen.
- R10: The alarm flag is bit 6 of the flags byte (select 13) and drives irq. It stays set until the flags byte is read, and a read clears it from the next cycle.
- R11: Bit 4 of the flags byte is a battery-low indication that always reads 0. Writes to the flags byte have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse once per second |
| sel | input | 4 | Register select |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; clears the alarm flag when it reads the flags byte |
| rd_data | output | 8 | Contents of the selected register |
| irq | output | 1 | Alarm interrupt, held until the flags byte is read |

## Verification
The case hardest to reach from the ports is a freeze release that carries a pending field write while the internal count has moved on. The stimulus freezes the copy, writes the minutes, sends two ticks and then releases. It checks that the written minutes survive and the seconds show the two ticks. Calendar boundaries such as 2000 and 2100 are reached by writing the date one second before midnight and sending a single tick. A behavioural model built on decimal integers tracks every cycle, so the alarm timing and the flag clear are compared cycle by cycle.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter logic [7:0] CENT_INIT = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam logic [3:0] CTRL  = 4'd12;
  localparam logic [3:0] FLAGS = 4'd13;

  function automatic logic [7:0] binc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic div4(input logic [7:0] v);
    return v[4] ? (v[3:0] == 4'd2 || v[3:0] == 4'd6)
                : (v[3:0] == 4'd0 || v[3:0] == 4'd4 || v[3:0] == 4'd8);
  endfunction

  logic [7:0] cur [8];
  logic [7:0] vis [8];
  logic [7:0] src [8];
  logic [7:0] nxt [8];
  logic [7:0] alm [4];
  logic [7:0] pend;
  logic [7:0] dim;
  logic       frz, tick_d, aflag;

  wire frz_nx = (wr_en && sel == CTRL) ? wr_data[0] : frz;
  wire rel    = frz & ~frz_nx;
  wire twr    = wr_en & ~sel[3];
  wire leap   = (src[6] != 8'h00) ? div4(src[6]) : div4(src[7]);
  wire match  = tick_d && alm[0] == cur[0] && alm[1] == cur[1] &&
                alm[2] == cur[2] && alm[3] == cur[4];

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      src[i] = cur[i];
      if (twr && !frz && sel[2:0] == 3'(i)) src[i] = wr_data;
      if (rel && pend[i]) src[i] = vis[i];
    end
  end

  always_comb begin
    case (src[5])
      8'h02:                      dim = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: dim = 8'h30;
      default:                    dim = 8'h31;
    endcase
  end

  always_comb begin
    nxt = src;
    if (tick) begin
      nxt[0] = binc(src[0]);
      if (src[0] == 8'h59) begin
        nxt[0] = 8'h00;
        nxt[1] = binc(src[1]);
        if (src[1] == 8'h59) begin
          nxt[1] = 8'h00;
          nxt[2] = binc(src[2]);
          if (src[2] == 8'h23) begin
            nxt[2] = 8'h00;
            nxt[3] = (src[3] == 8'h07) ? 8'h01 : src[3] + 8'd1;
            nxt[4] = binc(src[4]);
            if (src[4] == dim) begin
              nxt[4] = 8'h01;
              nxt[5] = binc(src[5]);
              if (src[5] == 8'h12) begin
                nxt[5] = 8'h01;
                nxt[6] = binc(src[6]);
                if (src[6] == 8'h99) begin
                  nxt[6] = 8'h00;
                  nxt[7] = (src[7] == 8'h99) ? 8'h00 : binc(src[7]);
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        cur[i] <= 8'h00;
        vis[i] <= 8'h00;
      end
      cur[3] <= 8'h01; cur[4] <= 8'h01; cur[5] <= 8'h01; cur[7] <= CENT_INIT;
      vis[3] <= 8'h01; vis[4] <= 8'h01; vis[5] <= 8'h01; vis[7] <= CENT_INIT;
      for (int i = 0; i < 4; i++) alm[i] <= 8'h00;
      pend   <= 8'h00;
      frz    <= 1'b0;
      tick_d <= 1'b0;
      aflag  <= 1'b0;
    end else begin
      cur <= nxt;
      if (!frz || rel) vis <= nxt;
      else if (twr) begin
        vis[sel[2:0]]  <= wr_data;
        pend[sel[2:0]] <= 1'b1;
      end
      if (rel) pend <= 8'h00;
      if (wr_en && sel[3:2] == 2'b10) alm[sel[1:0]] <= wr_data;
      frz    <= frz_nx;
      tick_d <= tick;
      if (match) aflag <= 1'b1;
      else if (rd_en && sel == FLAGS) aflag <= 1'b0;
    end
  end

  always_comb begin
    if (!sel[3]) rd_data = vis[sel[2:0]];
    else if (!sel[2]) rd_data = alm[sel[1:0]];
    else if (sel == CTRL) rd_data = {7'd0, frz};
    else if (sel == FLAGS) rd_data = {1'b0, aflag, 6'd0};
    else rd_data = 8'h00;
  end

  assign irq = aflag;

  wire [63:0] cur_flat = {cur[7], cur[6], cur[5], cur[4], cur[3], cur[2], cur[1], cur[0]};
  wire [63:0] vis_flat = {vis[7], vis[6], vis[5], vis[4], vis[3], vis[2], vis[1], vis[0]};

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cur_flat));

  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !wr_en) |=> $stable(vis_flat));

  assert_irq_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick, 2));

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(rd_en && sel == FLAGS)) |=> irq);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == FLAGS && !tick_d) |=> !irq);
endmodule

// File: tb/test_bcd_rtc.sv
module test_bcd_rtc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tk = 1'b0, we = 1'b0, re = 1'b0;
  logic [3:0] sl = 4'd0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd_data;
  logic irq;

  int tests = 0, fails = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  bcd_rtc i_bcd_rtc (.clk(clk), .rst_n(rst_n), .tick(tk), .sel(sl), .wr_en(we),
                     .wr_data(wd), .rd_en(re), .rd_data(rd_data), .irq(irq));

  int it[8], vs[8], sr[8];
  logic [7:0] am[4];
  bit fz, tdm, flg;
  bit pend[8];

  function automatic int b2d(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] d2b(int d);
    return {4'(d / 10), 4'(d % 10)};
  endfunction
  function automatic bit is_leap(int c, int y);
    int f = c * 100 + y;
    return (f % 4 == 0 && f % 100 != 0) || f % 400 == 0;
  endfunction
  function automatic int mdays(int c, int y, int m);
    if (m == 2) return is_leap(c, y) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      it = '{0, 0, 0, 1, 1, 1, 0, 20};
      vs = it;
      for (int i = 0; i < 4; i++) am[i] = 8'h00;
      for (int i = 0; i < 8; i++) pend[i] = 0;
      fz = 0; tdm = 0; flg = 0;
    end else begin
      automatic bit mt = tdm && am[0] == d2b(it[0]) && am[1] == d2b(it[1]) &&
                         am[2] == d2b(it[2]) && am[3] == d2b(it[4]);
      automatic bit fzn = (we && sl == 4'd12) ? wd[0] : fz;
      automatic bit rel = fz && !fzn;
      sr = it;
      if (we && sl < 4'd8 && !fz) sr[sl[2:0]] = b2d(wd);
      if (rel) for (int i = 0; i < 8; i++) if (pend[i]) sr[i] = vs[i];
      if (tk) begin
        sr[0]++;
        if (sr[0] == 60) begin
          sr[0] = 0; sr[1]++;
          if (sr[1] == 60) begin
            sr[1] = 0; sr[2]++;
            if (sr[2] == 24) begin
              sr[2] = 0;
              sr[3] = (sr[3] == 7) ? 1 : sr[3] + 1;
              sr[4]++;
              if (sr[4] > mdays(sr[7], sr[6], sr[5])) begin
                sr[4] = 1; sr[5]++;
                if (sr[5] == 13) begin
                  sr[5] = 1; sr[6]++;
                  if (sr[6] == 100) begin
                    sr[6] = 0; sr[7] = (sr[7] + 1) % 100;
                  end
                end
              end
            end
          end
        end
      end
      if (!fz || rel) vs = sr;
      else if (we && sl < 4'd8) begin
        vs[sl[2:0]] = b2d(wd);
        pend[sl[2:0]] = 1;
      end
      if (rel) for (int i = 0; i < 8; i++) pend[i] = 0;
      it = sr;
      if (mt) flg = 1;
      else if (re && sl == 4'd13) flg = 0;
      fz = fzn;
      tdm = tk;
      if (we && sl[3:2] == 2'b10) am[sl[1:0]] = wd;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] exp;
      if (sl < 4'd8) exp = d2b(vs[sl[2:0]]);
      else if (sl < 4'd12) exp = am[sl[1:0]];
      else if (sl == 4'd12) exp = {7'd0, fz};
      else if (sl == 4'd13) exp = {1'b0, flg, 6'd0};
      else exp = 8'h00;
      tests++;
      if (rd_data !== exp || irq !== flg) begin
        fails++;
        $display("FAIL %s model: rd_data=%h irq=%b expected rd_data=%h irq=%b", phase, rd_data, irq, exp, flg);
      end
    end
  end

  task automatic drive(input logic [3:0] s, input logic w, input logic [7:0] d,
                       input logic r, input logic t);
    @(posedge clk); #1;
    sl = s; we = w; wd = d; re = r; tk = t;
  endtask
  task automatic idle(input int n);
    repeat (n) drive(4'd0, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask
  task automatic wreg(input logic [3:0] s, input logic [7:0] d);
    drive(s, 1'b1, d, 1'b0, 1'b0);
  endtask
  task automatic ticks(input int n);
    repeat (n) drive(4'd0, 1'b0, 8'h00, 1'b0, 1'b1);
  endtask
  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask
  task automatic peek(input logic [3:0] s, input logic [7:0] exp, input string tag);
    drive(s, 1'b0, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    chk(rd_data, exp, tag);
  endtask
  task automatic peek_irq(input logic exp, input string tag);
    idle(1);
    @(negedge clk);
    chk({7'd0, irq}, {7'd0, exp}, tag);
  endtask
  task automatic to_midnight(input logic [7:0] c, input logic [7:0] y,
                             input logic [7:0] m, input logic [7:0] d);
    wreg(4'd7, c); wreg(4'd6, y); wreg(4'd5, m); wreg(4'd4, d);
    wreg(4'd2, 8'h23); wreg(4'd1, 8'h59); wreg(4'd0, 8'h59);
    ticks(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    phase = "R1";
    peek(4'd0, 8'h00, "R1 seconds");
    peek(4'd7, 8'h20, "R1 century");
    peek(4'd4, 8'h01, "R1 date");
    peek(4'd13, 8'h00, "R1 flags");
    peek_irq(1'b0, "R1 irq");

    phase = "R2";
    ticks(5);
    peek(4'd0, 8'h05, "R2 seconds after 5 ticks");
    ticks(7);
    peek(4'd0, 8'h12, "R2 BCD carry into tens");

    phase = "R7";
    wreg(4'd2, 8'h23); wreg(4'd1, 8'h59); wreg(4'd0, 8'h59);
    peek(4'd1, 8'h59, "R7 unfrozen write visible");
    ticks(1);
    phase = "R2";
    peek(4'd2, 8'h00, "R2 hour wrap");
    peek(4'd1, 8'h00, "R2 minute wrap");
    peek(4'd4, 8'h02, "R2 date advance");
    phase = "R5";
    peek(4'd3, 8'h02, "R5 day of week step");

    phase = "R3";
    to_midnight(8'h20, 8'h05, 8'h04, 8'h30);
    peek(4'd4, 8'h01, "R3 30-day month date");
    peek(4'd5, 8'h05, "R3 30-day month rollover");
    to_midnight(8'h20, 8'h05, 8'h05, 8'h30);
    peek(4'd4, 8'h31, "R3 31-day month continues");
    to_midnight(8'h20, 8'h99, 8'h12, 8'h31);
    peek(4'd6, 8'h00, "R3 year wrap");
    peek(4'd7, 8'h21, "R3 century advance");
    peek(4'd5, 8'h01, "R3 month wrap");

    phase = "R4";
    to_midnight(8'h20, 8'h24, 8'h02, 8'h28);
    peek(4'd4, 8'h29, "R4 2024 leap");
    to_midnight(8'h20, 8'h00, 8'h02, 8'h28);
    peek(4'd4, 8'h29, "R4 2000 leap");
    to_midnight(8'h21, 8'h00, 8'h02, 8'h28);
    peek(4'd5, 8'h03, "R4 2100 not leap");
    to_midnight(8'h20, 8'h23, 8'h02, 8'h28);
    peek(4'd4, 8'h01, "R4 2023 not leap");

    phase = "R5";
    wreg(4'd3, 8'h07);
    to_midnight(8'h20, 8'h23, 8'h03, 8'h10);
    peek(4'd3, 8'h01, "R5 day of week wrap");

    phase = "R6";
    wreg(4'd0, 8'h10);
    wreg(4'd12, 8'h01);
    ticks(3);
    peek(4'd0, 8'h10, "R6 frozen seconds held");
    peek(4'd12, 8'h01, "R6 control reads freeze");
    wreg(4'd12, 8'h00);
    peek(4'd0, 8'h13, "R6 release shows internal");

    phase = "R8";
    wreg(4'd12, 8'h01);
    wreg(4'd1, 8'h42);
    peek(4'd1, 8'h42, "R8 frozen write reads back");
    ticks(2);
    peek(4'd0, 8'h13, "R8 seconds still frozen");
    wreg(4'd12, 8'h00);
    peek(4'd1, 8'h42, "R8 pending field loaded");
    peek(4'd0, 8'h15, "R8 other field advanced");

    phase = "R9";
    wreg(4'd4, 8'h05); wreg(4'd2, 8'h10); wreg(4'd1, 8'h20); wreg(4'd0, 8'h30);
    wreg(4'd8, 8'h32); wreg(4'd9, 8'h20); wreg(4'd10, 8'h10); wreg(4'd11, 8'h05);
    ticks(1);
    idle(3);
    peek_irq(1'b0, "R9 no match yet");
    ticks(1);
    idle(1);
    peek_irq(1'b1, "R9 alarm match");
    phase = "R10";
    ticks(2);
    idle(2);
    peek_irq(1'b1, "R10 irq held");
    drive(4'd13, 1'b0, 8'h00, 1'b1, 1'b0);
    @(negedge clk);
    chk(rd_data, 8'h40, "R10 flags alarm bit");
    peek_irq(1'b0, "R10 cleared by read");

    phase = "R9";
    wreg(4'd0, 8'h30);
    wreg(4'd12, 8'h01);
    ticks(2);
    idle(1);
    peek_irq(1'b1, "R9 alarm while frozen");
    wreg(4'd12, 8'h00);
    drive(4'd13, 1'b0, 8'h00, 1'b1, 1'b0);

    phase = "R11";
    wreg(4'd13, 8'hFF);
    peek(4'd13, 8'h00, "R11 flags write ignored, battery bit 0");
    peek_irq(1'b0, "R11 irq unaffected");

    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule